// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 14-bit successive-approximation converter. A rising edge on the convert input starts a conversion. The sequencer then puts a trial code on the DAC port and settles one binary-weighted bit per step, starting at the most significant bit. At the end of each step it keeps or clears the bit under test according to the comparator input. When the last bit is decided, it returns a two's-complement result in the same clock edge and pulses a done strobe. The capacitor array, the comparator and the serial read-out sit outside this block.

Three operating modes trade speed against idle power. The fast mode takes 0.7 us per conversion, the default mode 0.9 us and the low-power mode 1.1 us. The cycle counts come from a clocks-per-microsecond parameter. In the low-power mode the controller stays in a power-down state between conversions. In the fast mode a result is marked invalid when too long a gap came before it.

Top module: `sar_seq_top`

## Requirements
- R1: A conversion starts on the first clock edge that samples `cnv` high after it was low. From the next cycle `busy` is high and `dac_code` holds only its MSB set (0x2000).
- R2: `busy` stays high for exactly CLK_PER_US*T/10 cycles, where T is 7, 9 or 11 for `mode` 0 (fast), 1 (default) or 2 (low-power). `mode` 3 behaves as 1. `mode` is sampled only at the start edge.
- R3: The result is the two's-complement code of the input, decided MSB first by binary search. `cmp_hi`=1 means the input is at or above the trial level, and trial code u stands for the signed level u-8192. Input 0 gives 0x0000, +1 gives 0x0001, -1 gives 0x3FFF, +8191 gives 0x1FFF and -8192 gives 0x2000.
- R4: An input above the top of the range yields 0x1FFF. An input below the bottom of the range yields 0x2000.
- R5: `done` pulses for one cycle on the edge where `busy` falls, and `result` and `result_valid` change on that same edge. `result` holds its value until the next `done`.
- R6: `cnv` edges while `busy` is high neither restart nor lengthen the conversion, and no extra `done` follows.
- R7: In `mode` 0, `result_valid` is 0 when more than CLK_PER_US*STALE_US cycles separate this start from the previous start of any mode. It is also 0 for the first conversion after reset. In all other modes `result_valid` is 1.
- R8: `pdown` goes high with `done` of a `mode` 2 conversion and stays high until the next start. It is low after conversions in the other modes and while `busy` is high.
- R9: After reset `busy`, `done`, `result`, `result_valid`, `pdown` and `dac_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Convert request; its rising edge starts a conversion |
| mode | input | 2 | Operating mode: 0 fast, 1 default, 2 low-power |
| cmp_hi | input | 1 | Comparator decision for the current trial code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe when the result is ready |
| result | output | NBITS | Two's-complement conversion result |
| result_valid | output | 1 | Result is not spoiled by a stale fast-mode gap |
| pdown | output | 1 | Power-down state between low-power conversions |
| dac_code | output | NBITS | Offset-binary trial code for the capacitor DAC |

## Verification
The comparator is modelled from an integer input level and the live trial code. Each conversion is therefore a real binary search. Inputs at midscale and one LSB either side show whether the sign bit and the low bits are coded correctly. The two full-scale points and the out-of-range levels on both sides separate correct clamping from wrap-around. All four mode codes are run at different input levels, so a wrong step count or a wrong mode decode shows up in the measured busy length. Long idle gaps are placed before fast-mode and default-mode conversions, and `cnv` is toggled in the middle of a conversion. These tell apart the validity rule, the power-down entry and exit, and the lock-out of new starts.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

   typedef enum logic [1:0] {
      MODE_FAST   = 2'd0,
      MODE_STD    = 2'd1,
      MODE_LOWPWR = 2'd2,
      MODE_RSVD   = 2'd3
   } sar_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_SLEEP = 2'd2
   } sar_state_e;

   // conversion time of each mode, in tenths of a microsecond
   function automatic int conv_tenths(input sar_mode_e m);
      case (m)
         MODE_FAST:   return 7;
         MODE_LOWPWR: return 11;
         default:     return 9;
      endcase
   endfunction

   // the reserved code falls back to the default mode
   function automatic sar_mode_e fold_mode(input logic [1:0] raw);
      return (raw == 2'd3) ? MODE_STD : sar_mode_e'(raw);
   endfunction

endpackage

// File: rtl/sar_step_plan.sv
`timescale 1ns/1ps
module sar_step_plan
   import sar_seq_pkg::*;
#(
   parameter int NBITS      = 14,
   parameter int CLK_PER_US = 100,
   parameter int CW         = 8
) (
   input  sar_mode_e       sel_mode,
   output logic [CW-1:0]   lead_cyc,
   output logic [CW-1:0]   step_cyc
);
   localparam int CYC_FAST = CLK_PER_US * 7 / 10;
   localparam int CYC_STD  = CLK_PER_US * 9 / 10;
   localparam int CYC_LOW  = CLK_PER_US * 11 / 10;
   localparam int STEP_FAST = CYC_FAST / NBITS;
   localparam int STEP_STD  = CYC_STD / NBITS;
   localparam int STEP_LOW  = CYC_LOW / NBITS;
   localparam int LEAD_FAST = CYC_FAST - STEP_FAST * NBITS;
   localparam int LEAD_STD  = CYC_STD - STEP_STD * NBITS;
   localparam int LEAD_LOW  = CYC_LOW - STEP_LOW * NBITS;

   generate
      if (NBITS < 2) begin : g_bad_width
         $error("sar_step_plan: NBITS must be at least 2");
      end
      if (CYC_FAST < NBITS) begin : g_bad_clock
         $error("sar_step_plan: clock too slow for one cycle per bit");
      end
      if (CYC_LOW >= (1 << CW)) begin : g_bad_cw
         $error("sar_step_plan: counter width too small");
      end
   endgenerate

   always_comb begin
      case (sel_mode)
         MODE_FAST: begin
            lead_cyc = CW'(LEAD_FAST);
            step_cyc = CW'(STEP_FAST);
         end
         MODE_LOWPWR: begin
            lead_cyc = CW'(LEAD_LOW);
            step_cyc = CW'(STEP_LOW);
         end
         default: begin
            lead_cyc = CW'(LEAD_STD);
            step_cyc = CW'(STEP_STD);
         end
      endcase
   end

endmodule

// File: rtl/sar_gap_timer.sv
`timescale 1ns/1ps
module sar_gap_timer #(
   parameter int LIMIT = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic stale
);
   localparam int TW = $clog2(LIMIT + 2);

   logic [TW-1:0] gap_q;
   logic          seen_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sar_gap_timer: LIMIT must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (start) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != TW'(LIMIT)) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // value read at a start edge is (cycles since previous start) - 1
   assign stale = !seen_q || (gap_q >= TW'(LIMIT));

   always @(posedge clk) begin
      if (rst_n) begin
         p_gap_saturates_r7: assert (gap_q <= TW'(LIMIT))
            else $error("gap counter beyond saturation");
      end
   end

endmodule

// File: rtl/sar_search_reg.sv
`timescale 1ns/1ps
module sar_search_reg #(
   parameter int NBITS = 14,
   parameter int IW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             decide,
   input  logic [IW-1:0]    idx,
   input  logic             cmp,
   output logic [NBITS-1:0] trial
);
   genvar gi;
   generate
      for (gi = 0; gi < NBITS; gi++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (load) begin
               bit_q <= (gi == NBITS - 1);
            end else if (decide && idx == IW'(gi)) begin
               bit_q <= cmp;
            end else if (decide && (gi < NBITS - 1) && idx == IW'(gi + 1)) begin
               bit_q <= 1'b1;
            end
         end
         assign trial[gi] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/sar_seq_top.sv
`timescale 1ns/1ps
module sar_seq_top
   import sar_seq_pkg::*;
#(
   parameter int NBITS      = 14,
   parameter int CLK_PER_US = 100,
   parameter int STALE_US   = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnv,
   input  logic [1:0]       mode,
   input  logic             cmp_hi,
   output logic             busy,
   output logic             done,
   output logic [NBITS-1:0] result,
   output logic             result_valid,
   output logic             pdown,
   output logic [NBITS-1:0] dac_code
);
   localparam int MAX_CYC = CLK_PER_US * 11 / 10;
   localparam int CW      = $clog2(MAX_CYC + 1);
   localparam int IW      = $clog2(NBITS);
   localparam int LIMIT   = CLK_PER_US * STALE_US;
   localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

   sar_state_e     state_q;
   sar_mode_e      mode_q, plan_mode, start_mode;
   logic           cnv_q, valid_q;
   logic [CW-1:0]  cnt_q, lead_c, step_c;
   logic [IW-1:0]  idx_q;
   logic           start, decide, stale;
   logic [NBITS-1:0] final_code;

   assign start_mode = fold_mode(mode);
   assign plan_mode  = (state_q == ST_CONV) ? mode_q : start_mode;
   assign start      = cnv && !cnv_q && (state_q != ST_CONV);
   assign decide     = (state_q == ST_CONV) && (cnt_q == '0);
   assign final_code = {dac_code[NBITS-1:1], cmp_hi};

   sar_step_plan #(.NBITS(NBITS), .CLK_PER_US(CLK_PER_US), .CW(CW)) u_plan (
      .sel_mode (plan_mode),
      .lead_cyc (lead_c),
      .step_cyc (step_c)
   );

   sar_gap_timer #(.LIMIT(LIMIT)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .stale (stale)
   );

   sar_search_reg #(.NBITS(NBITS), .IW(IW)) u_search (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .decide (decide),
      .idx    (idx_q),
      .cmp    (cmp_hi),
      .trial  (dac_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         mode_q       <= MODE_STD;
         cnv_q        <= 1'b0;
         cnt_q        <= '0;
         idx_q        <= '0;
         valid_q      <= 1'b0;
         done         <= 1'b0;
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         cnv_q <= cnv;
         done  <= 1'b0;
         if (start) begin
            state_q <= ST_CONV;
            mode_q  <= start_mode;
            idx_q   <= IW'(NBITS - 1);
            cnt_q   <= lead_c + step_c - 1'b1;
            valid_q <= !((start_mode == MODE_FAST) && stale);
         end else if (state_q == ST_CONV) begin
            if (decide) begin
               if (idx_q == '0) begin
                  state_q      <= (mode_q == MODE_LOWPWR) ? ST_SLEEP : ST_IDLE;
                  done         <= 1'b1;
                  result       <= {~final_code[NBITS-1], final_code[NBITS-2:0]};
                  result_valid <= valid_q;
               end else begin
                  idx_q <= idx_q - 1'b1;
                  cnt_q <= step_c - 1'b1;
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign busy  = (state_q == ST_CONV);
   assign pdown = (state_q == ST_SLEEP);

   p_start_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> dac_code == MSB_ONLY);

   p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   p_no_early_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdown) |-> done);

   p_sleep_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pdown |-> !busy);

endmodule

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
   localparam int TCLK  = 10;
   localparam int NB    = 14;
   localparam int CPU   = 30;
   localparam int STUS  = 1000;
   localparam int LIMIT = CPU * STUS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnv = 1'b0;
   logic [1:0] mode = 2'd1;
   logic cmp_hi;
   logic busy, done, result_valid, pdown;
   logic [NB-1:0] result, dac_code;

   int vin_r = 0;
   int cyc = 0;
   int checks = 0;
   int fails = 0;
   int last_start = 0;
   bit first = 1'b1;
   bit finished = 1'b0;

   logic [NB-1:0] q_res[$];
   bit            q_val[$];
   int            q_len[$];
   bit            q_slp[$];
   string         q_tag[$];

   always #(TCLK/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign cmp_hi = ((vin_r + 8192) >= int'({18'd0, dac_code}));

   sar_seq_top #(.NBITS(NB), .CLK_PER_US(CPU), .STALE_US(STUS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cnv(cnv), .mode(mode), .cmp_hi(cmp_hi),
      .busy(busy), .done(done), .result(result), .result_valid(result_valid),
      .pdown(pdown), .dac_code(dac_code)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: counts busy cycles and compares each finished conversion
   int busy_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_len++;
         if (done) begin
            if (q_res.size() == 0) begin
               chk(1'b0, "R6 unexpected done", 1, 0);
            end else begin
               logic [NB-1:0] er;
               bit ev, es;
               int el;
               string tg;
               er = q_res.pop_front(); ev = q_val.pop_front();
               el = q_len.pop_front(); es = q_slp.pop_front(); tg = q_tag.pop_front();
               chk(result == er, {tg, " result"}, int'(result), int'(er));
               chk(result_valid == ev, "R7 result_valid", int'(result_valid), int'(ev));
               chk(busy_len == el, "R2 busy length", busy_len, el);
               chk(pdown == es, "R8 pdown at done", int'(pdown), int'(es));
               chk(!busy, "R5 busy low with done", int'(busy), 0);
            end
            busy_len = 0;
         end
      end
   end

   task automatic convert(input int vin, input int md, input bit wiggle, input string tag);
      int vc, tenths, st;
      bit ev;
      @(negedge clk);
      vin_r = vin;
      mode  = md[1:0];
      vc = (vin > 8191) ? 8191 : ((vin < -8192) ? -8192 : vin);
      tenths = (md == 0) ? 7 : ((md == 2) ? 11 : 9);
      st = cyc + 1;
      ev = !(md == 0 && (first || (st - last_start) > LIMIT));
      first = 1'b0;
      last_start = st;
      q_res.push_back(NB'(vc));
      q_val.push_back(ev);
      q_len.push_back(CPU * tenths / 10);
      q_slp.push_back(md == 2);
      q_tag.push_back(tag);
      cnv = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R1 busy after edge", int'(busy), 1);
      chk(dac_code == 14'h2000, "R1 first trial code", int'(dac_code), 'h2000);
      chk(pdown == 1'b0, "R8 pdown low while busy", int'(pdown), 0);
      mode = 2'd2 - md[1:0];  // mode changes mid-conversion must not matter (R2)
      if (wiggle) begin
         cnv = 1'b0; @(negedge clk);
         cnv = 1'b1; @(negedge clk);
         cnv = 1'b0; @(negedge clk);
         cnv = 1'b1; @(negedge clk);
      end
      cnv = 1'b0;
      for (int t = 0; t < 400 && q_res.size() > 0; t++) @(negedge clk);
      if (q_res.size() > 0) begin
         chk(1'b0, "watchdog conversion hang", 0, 1);
         q_res.delete(); q_val.delete(); q_len.delete(); q_slp.delete(); q_tag.delete();
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(TCLK * 190000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R9 reset state
      chk({busy, done, result_valid, pdown} == 4'b0, "R9 reset flags",
          int'({busy, done, result_valid, pdown}), 0);
      chk(result == '0, "R9 reset result", int'(result), 0);
      chk(dac_code == '0, "R9 reset dac", int'(dac_code), 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      convert(0, 0, 1'b0, "R3 midscale fast first");   // R7: first after reset invalid
      convert(1, 0, 1'b0, "R3 plus one");
      convert(-1, 1, 1'b0, "R3 minus one");
      convert(8191, 2, 1'b0, "R3 top code");
      idle(5);
      chk(pdown == 1'b1, "R8 pdown held while idle", int'(pdown), 1);
      convert(-8192, 1, 1'b0, "R3 bottom code");
      chk(pdown == 1'b0, "R8 pdown cleared", int'(pdown), 0);
      convert(12000, 3, 1'b0, "R4 over range");
      convert(-20000, 0, 1'b0, "R4 under range");
      convert(2730, 2, 1'b0, "R3 pattern a");
      convert(-4661, 0, 1'b0, "R3 pattern b");
      convert(1234, 1, 1'b1, "R6 wiggle");
      idle(60);
      chk(q_res.size() == 0 && !busy, "R6 no restart", int'(busy), 0);
      idle(LIMIT + 50);
      convert(-77, 0, 1'b0, "R7 stale fast");
      convert(77, 0, 1'b0, "R7 fresh fast");
      idle(LIMIT + 50);
      convert(5000, 1, 1'b0, "R7 long gap default");
      convert(-5000, 0, 1'b0, "R7 fast after default");
      chk(result == 14'(-5000), "R5 result held", int'(result), int'(14'(-5000)));

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule